// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Sequencer

This block turns a single PWM request into two gate enables for a synchronous step-down power stage: one for the high-side switch and one for the low-side switch. It never hands over from one switch to the other on a timer. It hands over when the analog comparators report that the previous switch is off. The low side may start only once the switch node has dropped below its threshold (flag `sw_low_i`). The high side may start only once the low-side gate voltage has collapsed (flag `lg_low_i`). With negative inductor current the switch node may never fall. A watchdog therefore turns the low side on after a fixed number of cycles.

During soft-start the control loop may not turn on the low side until the first PWM high pulse has been seen. This prevents a pre-biased output from being discharged. The protection manager has two overrides, which work during soft-start as well. One forces the high side off. The other requests the low side on, but only through the normal dead-time handshake.

All comparator flags and overrides are synchronous to `clk_i`. Both enables come from a registered phase state.

Top module: `dt_gate_ctrl`

## Requirements
- R1: During and after reset, before any stimulus, `hs_en_o` and `ls_en_o` are both 0.
- R2: After PWM asks for the high side, `hs_en_o` stays 0 until `lg_low_i` (1 = low-gate voltage below threshold) is sampled high. It rises on the clock edge after that sample.
- R3: After the high side turns off, `ls_en_o` stays 0 while `sw_low_i` (1 = switch node below threshold) is 0. It rises on the edge after `sw_low_i` is sampled high.
- R4: If `sw_low_i` stays 0 after the high side turns off and the low side is wanted, `ls_en_o` rises exactly `WD_CYCLES` cycles after the edge on which `hs_en_o` fell (default 16).
- R5: While `ss_active_i` is 1 and PWM has not been high since soft-start began, the control loop never asserts `ls_en_o`.
- R6: Once PWM has been high during soft-start, a following low PWM phase turns on the low side as usual.
- R7: `force_ls_on_i` turns on the low side even during the soft-start hold-off, through the same R3/R4 dead-time condition.
- R8: `force_hs_off_i` takes priority over PWM. `hs_en_o` falls on the next edge and cannot rise while the override is held.
- R9: `force_ls_on_i` asserted while the high side is on turns the high side off on the next edge. The low side then follows only after the R3/R4 condition.
- R10: `hs_en_o` and `ls_en_o` are never 1 together, and at least one cycle with both at 0 separates them.
- R11: If PWM drops back before the high side has started, no high-side pulse is produced and the low side is restored through its dead-time condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwm_i | input | 1 | PWM request, 1 = high side wanted |
| sw_low_i | input | 1 | Switch node below turn-on threshold |
| lg_low_i | input | 1 | Low-side gate voltage discharged |
| ss_active_i | input | 1 | Soft-start in progress |
| force_hs_off_i | input | 1 | Protection: force high side off |
| force_ls_on_i | input | 1 | Protection: request low side on |
| hs_en_o | output | 1 | High-side gate enable |
| ls_en_o | output | 1 | Low-side gate enable |

## Verification
A wrong phase state shows at the enables on the next clock edge. The typical symptoms are a gate that turns on without its flag, one that never turns on, or both gates switching with no dead cycle between them. The bench withholds each flag for several cycles to catch a sequencer that skips its wait. A watchdog counter that is off by one moves the low-side turn-on by one cycle. The bench therefore samples exactly one cycle before and one cycle after the expected edge. A hold-off latch that clears too early turns the low side on during a pre-biased start, which is seen at once on `ls_en_o`.

// File: rtl/dt_gate_pkg.sv
package dt_gate_pkg;
  typedef enum logic [2:0] {
    PH_OFF     = 3'd0,
    PH_WAIT_HS = 3'd1,
    PH_HS      = 3'd2,
    PH_WAIT_LS = 3'd3,
    PH_LS      = 3'd4
  } phase_e;
endpackage

// File: rtl/dt_wdog.sv
module dt_wdog #(
  parameter int unsigned WD_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expired_o
);
  localparam int unsigned CNT_W = (WD_CYCLES < 2) ? 1 : $clog2(WD_CYCLES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WD_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!run_i)        cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = run_i && (cnt_q == LAST);

  // R4: the count restarts whenever the wait is left
  assert_wd_restart_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !expired_o || (WD_CYCLES == 1));
endmodule

// File: rtl/dt_prebias_hold.sv
module dt_prebias_hold (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ss_active_i,
  input  logic pwm_i,
  output logic holdoff_o
);
  logic seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           seen_q <= 1'b0;
    else if (!ss_active_i) seen_q <= 1'b0;
    else if (pwm_i)        seen_q <= 1'b1;
  end

  assign holdoff_o = ss_active_i && !seen_q;

  // R6: a high PWM sample during soft-start lifts the hold-off
  assert_holdoff_lift_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ss_active_i && pwm_i) |=> !holdoff_o);
endmodule

// File: rtl/dt_phase_fsm.sv
module dt_phase_fsm
  import dt_gate_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwm_i,
  input  logic sw_low_i,
  input  logic lg_low_i,
  input  logic holdoff_i,
  input  logic force_hs_off_i,
  input  logic force_ls_on_i,
  input  logic wd_expired_i,
  output logic wd_run_o,
  output logic hs_en_o,
  output logic ls_en_o
);
  phase_e state_q, state_d;
  logic want_hs, want_ls;

  // protection requests dominate the loop request
  assign want_hs = pwm_i && !force_hs_off_i && !force_ls_on_i;
  assign want_ls = force_ls_on_i || (!pwm_i && !holdoff_i);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PH_OFF: begin
        if (want_hs)      state_d = PH_WAIT_HS;
        else if (want_ls) state_d = PH_WAIT_LS;
      end
      PH_WAIT_HS: begin
        if (!want_hs)      state_d = want_ls ? PH_WAIT_LS : PH_OFF;
        else if (lg_low_i) state_d = PH_HS;
      end
      PH_HS: begin
        if (!want_hs) state_d = want_ls ? PH_WAIT_LS : PH_OFF;
      end
      PH_WAIT_LS: begin
        if (want_hs)                       state_d = PH_WAIT_HS;
        else if (!want_ls)                 state_d = PH_OFF;
        else if (sw_low_i || wd_expired_i) state_d = PH_LS;
      end
      PH_LS: begin
        if (!want_ls) state_d = want_hs ? PH_WAIT_HS : PH_OFF;
      end
      default: state_d = PH_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= PH_OFF;
    else         state_q <= state_d;
  end

  assign hs_en_o  = (state_q == PH_HS);
  assign ls_en_o  = (state_q == PH_LS);
  assign wd_run_o = (state_q == PH_WAIT_LS);

  assert_hs_after_lg_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hs_en_o) |-> $past(lg_low_i));

  assert_ls_after_node_or_wd_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ls_en_o) |-> ($past(sw_low_i) || $past(wd_expired_i)));

  assert_prebias_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ls_en_o) |-> (!$past(holdoff_i) || $past(force_ls_on_i)));

  assert_force_hs_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (force_hs_off_i && hs_en_o) |=> !hs_en_o);

  assert_force_ls_drops_hs_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (force_ls_on_i && hs_en_o) |=> (!hs_en_o && !ls_en_o));

  assert_dead_cycle_ls_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ls_en_o) |-> !$past(hs_en_o));

  assert_dead_cycle_hs_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hs_en_o) |-> !$past(ls_en_o));
endmodule

// File: rtl/dt_gate_ctrl.sv
module dt_gate_ctrl #(
  parameter int unsigned WD_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwm_i,
  input  logic sw_low_i,
  input  logic lg_low_i,
  input  logic ss_active_i,
  input  logic force_hs_off_i,
  input  logic force_ls_on_i,
  output logic hs_en_o,
  output logic ls_en_o
);
  logic holdoff, wd_run, wd_expired;

  dt_prebias_hold i_hold (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ss_active_i (ss_active_i),
    .pwm_i       (pwm_i),
    .holdoff_o   (holdoff)
  );

  dt_wdog #(.WD_CYCLES(WD_CYCLES)) i_wdog (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (wd_run),
    .expired_o (wd_expired)
  );

  dt_phase_fsm i_fsm (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .pwm_i          (pwm_i),
    .sw_low_i       (sw_low_i),
    .lg_low_i       (lg_low_i),
    .holdoff_i      (holdoff),
    .force_hs_off_i (force_hs_off_i),
    .force_ls_on_i  (force_ls_on_i),
    .wd_expired_i   (wd_expired),
    .wd_run_o       (wd_run),
    .hs_en_o        (hs_en_o),
    .ls_en_o        (ls_en_o)
  );
endmodule

// File: tb/test_dt_gate_ctrl.sv
`timescale 1ns/1ps
module test_dt_gate_ctrl;
  localparam int WD = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic pwm = 0, sw_low = 0, lg_low = 0, ss = 0, f_hs_off = 0, f_ls_on = 0;
  logic hs_en, ls_en;
  int checks = 0, failures = 0;
  int overlap = 0, no_dead = 0;
  logic prev_hs = 0, prev_ls = 0;

  always #2.5 clk = ~clk;

  dt_gate_ctrl #(.WD_CYCLES(WD)) i_dt_gate_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .pwm_i(pwm), .sw_low_i(sw_low), .lg_low_i(lg_low),
    .ss_active_i(ss), .force_hs_off_i(f_hs_off), .force_ls_on_i(f_ls_on),
    .hs_en_o(hs_en), .ls_en_o(ls_en)
  );

  // R10 monitor
  always @(negedge clk) begin
    if (rst_ni) begin
      if (hs_en && ls_en) overlap++;
      if ((prev_hs && ls_en) || (prev_ls && hs_en)) no_dead++;
    end
    prev_hs = hs_en;
    prev_ls = ls_en;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  task automatic do_reset();
    rst_ni = 0; pwm = 0; sw_low = 0; lg_low = 0; ss = 0; f_hs_off = 0; f_ls_on = 0;
    tick(2);
    check("R1 hs in reset", hs_en, 1'b0);
    check("R1 ls in reset", ls_en, 1'b0);
    rst_ni = 1;
    tick(1);
    check("R1 hs after reset", hs_en, 1'b0);
    check("R1 ls after reset", ls_en, 1'b0);
  endtask

  // normal handover in both directions
  task automatic t_normal();
    sw_low = 1; lg_low = 1; pwm = 0;
    tick(3);
    check("R3 start ls", ls_en, 1'b1);
    pwm = 1; lg_low = 0;
    tick(1);
    check("R2 dead after ls", ls_en, 1'b0);
    tick(3);
    check("R2 hs waits lg_low", hs_en, 1'b0);
    lg_low = 1;
    tick(1);
    check("R2 hs on", hs_en, 1'b1);
    sw_low = 0; pwm = 0;
    tick(1);
    check("R3 hs off", hs_en, 1'b0);
    tick(2);
    check("R3 ls waits sw_low", ls_en, 1'b0);
    sw_low = 1;
    tick(1);
    check("R3 ls on", ls_en, 1'b1);
  endtask

  // negative current: node never falls
  task automatic t_watchdog();
    pwm = 1; lg_low = 1;
    tick(2);
    check("R4 hs on first", hs_en, 1'b1);
    sw_low = 0; pwm = 0;
    tick(1);
    check("R4 hs off", hs_en, 1'b0);
    tick(WD - 1);
    check("R4 ls before timeout", ls_en, 1'b0);
    tick(1);
    check("R4 ls at timeout", ls_en, 1'b1);
  endtask

  task automatic t_prebias();
    do_reset();
    ss = 1; sw_low = 1; lg_low = 1;
    tick(6);
    check("R5 ls held", ls_en, 1'b0);
    pwm = 1;
    tick(2);
    check("R6 first pulse hs", hs_en, 1'b1);
    pwm = 0;
    tick(1);
    check("R6 dead cycle", ls_en, 1'b0);
    tick(1);
    check("R6 ls after pulse", ls_en, 1'b1);
    ss = 0;
  endtask

  task automatic t_force_ls_in_ss();
    do_reset();
    ss = 1; sw_low = 0; lg_low = 1; f_ls_on = 1;
    tick(2);
    check("R7 waits sw_low", ls_en, 1'b0);
    sw_low = 1;
    tick(1);
    check("R7 forced ls on", ls_en, 1'b1);
    f_ls_on = 0;
    tick(1);
    check("R5 hold resumes", ls_en, 1'b0);
    tick(3);
    check("R5 still held", ls_en, 1'b0);
    ss = 0;
  endtask

  task automatic t_force_hs_off();
    lg_low = 1; pwm = 1;
    tick(3);
    check("R8 hs on first", hs_en, 1'b1);
    f_hs_off = 1;
    tick(1);
    check("R8 hs forced off", hs_en, 1'b0);
    tick(5);
    check("R8 hs stays off", hs_en, 1'b0);
    check("R8 ls stays off", ls_en, 1'b0);
    f_hs_off = 0;
    tick(2);
    check("R8 hs after release", hs_en, 1'b1);
  endtask

  task automatic t_force_ls_from_hs();
    sw_low = 0; f_ls_on = 1;
    tick(1);
    check("R9 hs dropped", hs_en, 1'b0);
    check("R9 ls not yet", ls_en, 1'b0);
    tick(1);
    check("R9 ls waits", ls_en, 1'b0);
    sw_low = 1;
    tick(1);
    check("R9 ls on", ls_en, 1'b1);
    f_ls_on = 0; lg_low = 1;
    tick(2);
    check("R9 back to hs", hs_en, 1'b1);
  endtask

  task automatic t_abort();
    logic hs_seen;
    pwm = 0; sw_low = 1;
    tick(2);
    check("R11 ls first", ls_en, 1'b1);
    hs_seen = 0;
    pwm = 1; lg_low = 0;
    tick(1);
    hs_seen |= hs_en;
    pwm = 0;
    tick(1);
    hs_seen |= hs_en;
    tick(1);
    hs_seen |= hs_en;
    check("R11 no hs pulse", hs_seen, 1'b0);
    check("R11 ls restored", ls_en, 1'b1);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    do_reset();
    t_normal();
    t_watchdog();
    t_prebias();
    t_force_ls_in_ss();
    do_reset();
    t_force_hs_off();
    t_force_ls_from_hs();
    t_abort();
    checks++;
    if (overlap != 0) begin
      failures++;
      $display("FAIL R10 overlap actual=%0d expected=0", overlap);
    end
    checks++;
    if (no_dead != 0) begin
      failures++;
      $display("FAIL R10 dead cycle actual=%0d expected=0", no_dead);
    end
    summary();
    $finish;
  end
endmodule